// File: doc/BRIEF.md
# Quad 3-bit Arithmetic Slice Array

This block holds four identical small arithmetic slices side by side. Each slice has its own pair of unsigned operands and its own 2-bit operation code. It can add, multiply, test whether the first operand is larger than the second, or shift the first operand right arithmetically. The adder is a carry-select adder built from half and full adder cells. The multiplier forms partial products with AND gates and sums them through a chain of those same carry-select adders.

A row bit and a column bit go to a 2-to-4 decoder, which enables exactly one slice. A slice that is not enabled drives zeros. A separate 2-bit output select steers one of the four slice results onto the shared result bus. The result therefore carries data only when the output select points at the enabled slice.

The block is purely combinational. It has no clock and no state, so the result follows the inputs within the same evaluation.

Top module: `cu_quad_array`

## Requirements
- R1: The operation code of each slice is 2 bits wide: 00 selects addition, 01 multiplication, 10 greater-than and 11 arithmetic shift right. With both operands equal to 3, the four codes give 6, 9, 0 and 0.
- R2: Addition gives the (DATA_W+1)-bit unsigned sum A+B in the low bits of the 2*DATA_W-bit result, with all higher bits zero.
- R3: Multiplication gives the full 2*DATA_W-bit unsigned product A*B.
- R4: Greater-than treats both operands as unsigned. It sets bit 0 to 1 when A > B and to 0 otherwise, and all other result bits are 0.
- R5: Arithmetic shift right shifts A, read as two's complement, right by the unsigned amount B. The vacated bits are filled with A's top bit, and the result is sign-extended to 2*DATA_W bits.
- R6: An arithmetic shift by DATA_W-1 or more places (2 or more for the default width) gives a result in which every bit equals A's top bit.
- R7: The decoder enables slice number {row_sel, col_sel}, with row_sel as the more significant bit. Exactly one slice is enabled for every combination of the two bits.
- R8: A slice that is not enabled outputs all zeros. The result is zero whenever out_sel differs from {row_sel, col_sel}, whatever the operands and operation codes.
- R9: The result equals the output of slice number out_sel. When that slice is enabled, the result is that slice's operation on that slice's own operands, independent of the other slices' inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4*DATA_W | Operand A for each slice; slice k uses bits [k*DATA_W +: DATA_W] |
| b_in | input | 4*DATA_W | Operand B for each slice; slice k uses bits [k*DATA_W +: DATA_W] |
| op_in | input | 8 | Operation code for each slice; slice k uses bits [2k +: 2] |
| row_sel | input | 1 | Decoder row bit (more significant bit of the enabled slice number) |
| col_sel | input | 1 | Decoder column bit (less significant bit of the enabled slice number) |
| out_sel | input | 2 | Number of the slice driven onto the result bus |
| result | output | 2*DATA_W | Selected slice output |

## Verification
The bench builds the block with DATA_W = 3, the default. At this width every operand pair of a slice (64 pairs) can be applied under every operation and in every slice position. This gives exhaustive coverage of the carry-select split, of the carry from the low half of the adder, of every multiplier partial-product chain, and of every shift amount, including the amounts that saturate to the sign. While one slice is under test, the other three slices get different operands and operation codes. A mis-steered decoder or output multiplexer therefore shows up as a wrong value rather than hiding behind identical data. All sixteen combinations of row, column and output select are swept as well.

// File: rtl/cu_pkg.sv
// Package cu_pkg
// Shared constants, the operation code type and the full adder cell used by
// the quad arithmetic slice array. Assumes four slices, fixed by the 2-to-4
// row/column decoder.
package cu_pkg;

    localparam int N_SLICES = 4;
    localparam int OP_W     = 2;
    localparam int SEL_W    = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'b00,
        OP_MUL = 2'b01,
        OP_GT  = 2'b10,
        OP_ASR = 2'b11
    } cu_op_e;

    // Full adder cell: returns {carry, sum}.
    function automatic logic [1:0] fa_cell(input logic x, input logic y, input logic ci);
        fa_cell = {(x & y) | (ci & (x ^ y)), x ^ y ^ ci};
    endfunction

endpackage

// File: rtl/cu_csel_adder.sv
// Module cu_csel_adder
// Unsigned W-bit carry-select adder with no carry input. The low part is a
// ripple chain that starts with a half adder. The high part is computed twice,
// once for each possible carry, and the low carry selects one result.
// Assumes W >= 2 so that both parts are at least one bit wide.
module cu_csel_adder #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);
    import cu_pkg::*;

    localparam int LO_W = (W + 1) / 2;
    localparam int HI_W = W - LO_W;

    logic [LO_W-1:0] lo_s;
    logic [LO_W:1]   lo_ch;
    logic [HI_W-1:0] hi0_s, hi1_s;
    logic [HI_W:0]   hi0_ch, hi1_ch;

    // Low part: half adder on bit 0, then a full adder ripple.
    always_comb begin
        lo_s[0]  = a[0] ^ b[0];
        lo_ch[1] = a[0] & b[0];
        for (int i = 1; i < LO_W; i++) begin
            {lo_ch[i+1], lo_s[i]} = fa_cell(a[i], b[i], lo_ch[i]);
        end
    end

    // High part: two speculative ripple chains, for carry 0 and carry 1.
    always_comb begin
        hi0_ch[0] = 1'b0;
        hi1_ch[0] = 1'b1;
        for (int i = 0; i < HI_W; i++) begin
            {hi0_ch[i+1], hi0_s[i]} = fa_cell(a[LO_W+i], b[LO_W+i], hi0_ch[i]);
            {hi1_ch[i+1], hi1_s[i]} = fa_cell(a[LO_W+i], b[LO_W+i], hi1_ch[i]);
        end
    end

    // Select stage: the low carry picks the high result.
    always_comb begin
        if (lo_ch[LO_W]) begin
            sum = {hi1_ch[HI_W], hi1_s, lo_s};
        end else begin
            sum = {hi0_ch[HI_W], hi0_s, lo_s};
        end
    end

    // Guard: the gate-level sum matches arithmetic addition (R2).
    always_comb begin
        a_r2_csel_sum: assert (sum == ({1'b0, a} + {1'b0, b}))
            else $error("carry-select sum wrong");
    end

endmodule

// File: rtl/cu_alu_slice.sv
// Module cu_alu_slice
// One arithmetic slice. It computes add, multiply, unsigned greater-than and
// arithmetic shift right on W-bit operands and places the chosen result on a
// 2W-bit output. The output is forced to zero when the slice is not enabled.
// Assumes W >= 2.
module cu_alu_slice #(
    parameter int W = 3
) (
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    input  logic [cu_pkg::OP_W-1:0] op,
    input  logic                  en,
    output logic [2*W-1:0]        y
);
    import cu_pkg::*;

    localparam int OUT_W = 2 * W;

    logic [W:0]       add_sum;
    logic [OUT_W-1:0] prod;
    logic             gt_flag;
    logic [OUT_W-1:0] asr_y;
    logic [OUT_W-1:0] res;

    // Addition datapath.
    cu_csel_adder #(.W(W)) u_add (
        .a   (a),
        .b   (b),
        .sum (add_sum)
    );

    // Multiplier: AND partial products summed by a chain of W-1 adders.
    logic [W-1:0] pp    [W];
    logic [W-1:0] up_in [W-1];
    logic [W:0]   part  [W-1];

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = a & {W{b[i]}};
    end

    assign up_in[0] = {1'b0, pp[0][W-1:1]};
    assign prod[0]  = pp[0][0];

    for (genvar i = 1; i < W; i++) begin : g_mul_row
        cu_csel_adder #(.W(W)) u_row (
            .a   (up_in[i-1]),
            .b   (pp[i]),
            .sum (part[i-1])
        );
        assign prod[i] = part[i-1][0];
        if (i < W - 1) begin : g_pass
            assign up_in[i] = part[i-1][W:1];
        end else begin : g_top
            assign prod[OUT_W-1:W] = part[i-1][W:1];
        end
    end

    // Unsigned magnitude compare, deciding at the most significant differing bit.
    always_comb begin
        logic decided;
        gt_flag = 1'b0;
        decided = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!decided && (a[i] != b[i])) begin
                gt_flag = a[i];
                decided = 1'b1;
            end
        end
    end

    // Arithmetic shifter: log stages on a sign-extended copy of A.
    logic [OUT_W-1:0] stg [W+1];
    assign stg[0] = {{W{a[W-1]}}, a};

    for (genvar k = 0; k < W; k++) begin : g_asr_stage
        localparam int S = ((1 << k) < W) ? (1 << k) : W;
        assign stg[k+1] = b[k] ? {{S{stg[k][OUT_W-1]}}, stg[k][OUT_W-1:S]} : stg[k];
    end
    assign asr_y = stg[W];

    // Result select by operation code.
    always_comb begin
        case (op)
            OP_ADD:  res = {{(OUT_W-W-1){1'b0}}, add_sum};
            OP_MUL:  res = prod;
            OP_GT:   res = {{(OUT_W-1){1'b0}}, gt_flag};
            default: res = asr_y;
        endcase
    end

    // Enable gating: an idle slice drives zeros.
    assign y = en ? res : '0;

    // Guards next to each datapath.
    always_comb begin
        a_r3_product: assert (prod == (OUT_W'(a) * OUT_W'(b)))
            else $error("product wrong");
        a_r4_unsigned_gt: assert (gt_flag == (a > b))
            else $error("compare wrong");
        a_r5_asr_value: assert ($signed(asr_y) == ($signed(a) >>> b))
            else $error("shift wrong");
        if (int'(b) >= W - 1) begin
            a_r6_asr_saturate: assert (asr_y == {OUT_W{a[W-1]}})
                else $error("saturated shift wrong");
        end
        if (!en) begin
            a_r8_idle_zero: assert (y == '0)
                else $error("idle slice not zero");
        end
    end

endmodule

// File: rtl/cu_rowcol_decoder.sv
// Module cu_rowcol_decoder
// 2-to-4 decoder. It enables slice number {row, col}, with row as the more
// significant bit. Assumes four slices.
module cu_rowcol_decoder (
    input  logic                        row,
    input  logic                        col,
    output logic [cu_pkg::N_SLICES-1:0] en
);
    import cu_pkg::*;

    // One AND term per slice, matching its row and column bits.
    for (genvar i = 0; i < N_SLICES; i++) begin : g_dec
        localparam logic [1:0] IDX = 2'(i);
        assign en[i] = (row == IDX[1]) && (col == IDX[0]);
    end

    // Guard: exactly one line is active, and it is the addressed one (R7).
    always_comb begin
        a_r7_one_enable: assert (($countones(en) == 1) && en[{row, col}])
            else $error("decoder enable wrong");
    end

endmodule

// File: rtl/cu_out_mux.sv
// Module cu_out_mux
// 4-to-1 multiplexer that puts the slice picked by sel onto the result bus.
// Assumes the inputs are packed slice after slice, slice 0 in the low bits.
module cu_out_mux #(
    parameter int OW = 6
) (
    input  logic [cu_pkg::N_SLICES*OW-1:0] din,
    input  logic [cu_pkg::SEL_W-1:0]      sel,
    output logic [OW-1:0]                 dout
);
    import cu_pkg::*;

    // Slice pick by select value.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N_SLICES; i++) begin
            if (int'(sel) == i) begin
                dout = din[i*OW +: OW];
            end
        end
    end

endmodule

// File: rtl/cu_quad_array.sv
// Module cu_quad_array
// Top of the quad arithmetic slice array. Four slices each have their own
// operands and operation code. A row/column decoder enables one slice, and an
// output multiplexer picks the slice shown on the result. Purely
// combinational: no clock or reset. Assumes DATA_W >= 2.
module cu_quad_array #(
    parameter int DATA_W = 3
) (
    input  logic [4*DATA_W-1:0] a_in,
    input  logic [4*DATA_W-1:0] b_in,
    input  logic [7:0]          op_in,
    input  logic                row_sel,
    input  logic                col_sel,
    input  logic [1:0]          out_sel,
    output logic [2*DATA_W-1:0] result
);
    import cu_pkg::*;

    localparam int OUT_W = 2 * DATA_W;

    logic [N_SLICES-1:0]       en;
    logic [N_SLICES*OUT_W-1:0] slice_y;

    // Slice enable decode.
    cu_rowcol_decoder u_dec (
        .row (row_sel),
        .col (col_sel),
        .en  (en)
    );

    // The four arithmetic slices.
    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        cu_alu_slice #(.W(DATA_W)) u_slice (
            .a  (a_in[k*DATA_W +: DATA_W]),
            .b  (b_in[k*DATA_W +: DATA_W]),
            .op (op_in[k*OP_W +: OP_W]),
            .en (en[k]),
            .y  (slice_y[k*OUT_W +: OUT_W])
        );
    end

    // Result steering.
    cu_out_mux #(.OW(OUT_W)) u_mux (
        .din  (slice_y),
        .sel  (out_sel),
        .dout (result)
    );

    // Guard: a selected but idle slice gives a zero result (R8).
    always_comb begin
        if (out_sel != {row_sel, col_sel}) begin
            a_r8_unselected_zero: assert (result == '0)
                else $error("result not zero for idle slice");
        end
    end

endmodule

// File: tb/test_cu_quad_array.sv
// Directed bench for cu_quad_array. Each task covers one scenario and checks
// its own results against a reference model written from the requirements.
module test_cu_quad_array;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 3;
    localparam int OW         = 2 * DW;
    localparam int NV         = 1 << DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [4*DW-1:0] a_in  = '0;
    logic [4*DW-1:0] b_in  = '0;
    logic [7:0]      op_in = '0;
    logic            row_sel = 1'b0;
    logic            col_sel = 1'b0;
    logic [1:0]      out_sel = '0;
    logic [OW-1:0]   result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    cu_quad_array #(.DATA_W(DW)) i_cu_quad_array (
        .a_in    (a_in),
        .b_in    (b_in),
        .op_in   (op_in),
        .row_sel (row_sel),
        .col_sel (col_sel),
        .out_sel (out_sel),
        .result  (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model of one slice.
    function automatic logic [OW-1:0] ref_y(input int a, input int b, input int op);
        int v;
        case (op)
            0: v = a + b;
            1: v = a * b;
            2: v = (a > b) ? 1 : 0;
            default: begin
                v = (a >= (1 << (DW-1))) ? a - (1 << DW) : a;
                for (int s = 0; s < b; s++) v = (v < 0) ? (v - 1) / 2 : v / 2;
            end
        endcase
        return OW'(v);
    endfunction

    function automatic int sat_w(input int v);
        return v & (NV - 1);
    endfunction

    // Drive slice tgt with the given values and the other slices with different ones.
    task automatic drive(input int tgt, input int a, input int b, input int op,
                         input int dec, input int sel);
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            if (m == tgt) begin
                a_in[m*DW +: DW] = DW'(a);
                b_in[m*DW +: DW] = DW'(b);
                op_in[m*2 +: 2]  = 2'(op);
            end else begin
                a_in[m*DW +: DW] = DW'(sat_w(a + m + 1));
                b_in[m*DW +: DW] = DW'(sat_w(b ^ (m + 2)));
                op_in[m*2 +: 2]  = 2'(op ^ (m + 1));
            end
        end
        row_sel = dec[1];
        col_sel = dec[0];
        out_sel = 2'(sel);
        #1;
    endtask

    task automatic check(input string tag, input logic [OW-1:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_fails++;
            $display("FAIL %s: result=%0h expected=%0h", tag, result, exp);
        end
    endtask

    // Zero inputs with slice 0 enabled and selected: 0 + 0.
    task automatic t_initial();
        drive(0, 0, 0, 0, 0, 0);
        check("R2 zero inputs", '0);
    endtask

    // R1: operation code map with A = B = 3.
    task automatic t_encoding();
        logic [OW-1:0] exp_v [4];
        exp_v[0] = 6; exp_v[1] = 9; exp_v[2] = 0; exp_v[3] = 0;
        for (int op = 0; op < 4; op++) begin
            drive(1, 3, 3, op, 1, 1);
            check("R1 op code", exp_v[op]);
        end
    endtask

    // One operation, every operand pair, every slice position.
    task automatic t_op_sweep(input int op, input string tag);
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < NV; a++)
                for (int b = 0; b < NV; b++) begin
                    drive(k, a, b, op, k, k);
                    if (op == 3 && b >= DW - 1)
                        check("R6 saturated shift", ref_y(a, b, op));
                    else
                        check(tag, ref_y(a, b, op));
                end
    endtask

    // R7: decoder addressing; every slice adds 1 + 1.
    task automatic t_decoder();
        for (int dec = 0; dec < 4; dec++)
            for (int sel = 0; sel < 4; sel++) begin
                @(negedge clk);
                a_in = {4{DW'(1)}};
                b_in = {4{DW'(1)}};
                op_in = '0;
                row_sel = dec[1];
                col_sel = dec[0];
                out_sel = 2'(sel);
                #1;
                check("R7 decoder", (sel == dec) ? OW'(2) : OW'(0));
            end
    endtask

    // R8 and R9: all select combinations with differing slice inputs.
    task automatic t_select();
        for (int dec = 0; dec < 4; dec++)
            for (int sel = 0; sel < 4; sel++)
                for (int op = 0; op < 4; op++)
                    for (int a = 0; a < NV; a++) begin
                        drive(sel, a, a ^ 3, op, dec, sel);
                        if (sel == dec)
                            check("R9 mux pick", ref_y(a, a ^ 3, op));
                        else
                            check("R8 idle zero", '0);
                    end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_initial();
        t_encoding();
        t_op_sweep(0, "R2 add");
        t_op_sweep(1, "R3 mul");
        t_op_sweep(2, "R4 gt");
        t_op_sweep(3, "R5 asr");
        t_decoder();
        t_select();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: result=%0h expected=completion", result);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule